// File: doc/BRIEF.md
# Multi-Source On-Chip Memory Port Scheduler

This block sits between four requesters and a banked, unified program/data memory. The requesters are a 32-bit peripheral-side port (shared upstream by a DMA engine and a host port, one access at a time), a 256-bit instruction fetch port, and two 64-bit processor data ports. Every cycle the scheduler looks at all pending requests, grants at most three of them, and drives each granted access onto the bank it addresses as a single-cycle memory access. A request that is not granted stays pending at its source and is tried again on the following cycle.

The memory is a set of independent banks, each one 256-bit line wide. Consecutive lines rotate across the banks, so the bank is chosen by the address bits just above the line offset. A narrow access lands in its own slot of the line and carries byte enables, so partial writes touch only the selected bytes. Read data for each port comes back one cycle after its grant, with a per-port valid strobe. The memory arrays live outside the block: here, behavioural models in the testbench.

Top module: `mps_sched`

## Requirements
- R1: The fetch port is read-only and returns a whole 256-bit line; address bits [4:0] of a fetch are ignored.
- R2: Byte address bits [6:5] (for the default of four banks) select the bank and the bits above them select the row, so lines differing only in the row field never alias.
- R3: No more than three requests are granted in any cycle; with four requests on four distinct banks the lowest-priority one waits.
- R4: No two requests granted in the same cycle address the same bank.
- R5: Conflicts and the three-grant limit are resolved by fixed priority: peripheral, then fetch, then data port 0, then data port 1.
- R6: A grant is given in the same cycle as the request it answers, never without a request, and each grant enables exactly one bank in that cycle.
- R7: Read data and its valid strobe appear on a port exactly one cycle after a read grant; the strobe stays low after writes and in idle cycles.
- R8: Byte enable bit k of a port writes byte k of that port's data into its slot (data slot = address bits [4:3], peripheral slot = bits [4:2]); all other bytes of the line keep their values.
- R9: A request that is refused has no effect on memory and is served on a later cycle if the requester keeps it asserted with its address and data held.
- R10: While reset is high no grant is given and all read valid strobes are low.
- R11: Program and data share one address space: a line written through data or peripheral ports is read back unchanged by the fetch port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_req | input | 1 | Peripheral-side request |
| pe_we | input | 1 | Peripheral write (1) or read (0) |
| pe_addr | input | ADDR_W | Peripheral byte address |
| pe_be | input | PE_W/8 | Peripheral byte enables |
| pe_wdata | input | PE_W | Peripheral write data |
| pe_gnt | output | 1 | Peripheral grant, same cycle |
| pe_rvalid | output | 1 | Peripheral read data valid |
| pe_rdata | output | PE_W | Peripheral read data |
| ft_req | input | 1 | Instruction fetch request |
| ft_addr | input | ADDR_W | Fetch byte address (line aligned) |
| ft_gnt | output | 1 | Fetch grant |
| ft_rvalid | output | 1 | Fetch data valid |
| ft_rdata | output | 256 | Fetched line |
| d0_req | input | 1 | Data port 0 request |
| d0_we | input | 1 | Data port 0 write |
| d0_addr | input | ADDR_W | Data port 0 byte address |
| d0_be | input | DP_W/8 | Data port 0 byte enables |
| d0_wdata | input | DP_W | Data port 0 write data |
| d0_gnt | output | 1 | Data port 0 grant |
| d0_rvalid | output | 1 | Data port 0 read valid |
| d0_rdata | output | DP_W | Data port 0 read data |
| d1_req | input | 1 | Data port 1 request |
| d1_we | input | 1 | Data port 1 write |
| d1_addr | input | ADDR_W | Data port 1 byte address |
| d1_be | input | DP_W/8 | Data port 1 byte enables |
| d1_wdata | input | DP_W | Data port 1 write data |
| d1_gnt | output | 1 | Data port 1 grant |
| d1_rvalid | output | 1 | Data port 1 read valid |
| d1_rdata | output | DP_W | Data port 1 read data |
| mem_en | output | NBANK | Per-bank access strobe |
| mem_row | output | NBANK x ROW_W | Per-bank row address |
| mem_be | output | NBANK x 32 | Per-bank byte write enables (zero on reads) |
| mem_wdata | output | NBANK x 256 | Per-bank write line |
| mem_rdata | input | NBANK x 256 | Per-bank read line, one cycle after the strobe |

## Verification
The assertions take for granted that a refused requester keeps its request up with the same address until granted, and that each bank model returns the addressed line on the cycle after its strobe. The stimulus respects this by only changing a port's request fields once the previous one was granted, in both the directed cases and the random phase. Expected grants come from a separate priority model and expected read data from a shadow copy of the memory keyed by line address, so a wrong bank or row split shows up as a data mismatch rather than relying on any internal signal.

// File: rtl/mps_pkg.sv
package mps_pkg;
  localparam int LINE_W  = 256;
  localparam int LINE_B  = LINE_W / 8;
  localparam int LINE_LO = $clog2(LINE_B);
  localparam int NPORT   = 4;

  // port index doubles as priority rank (0 = highest)
  typedef enum logic [1:0] {
    PRT_PE = 2'd0,
    PRT_FT = 2'd1,
    PRT_D0 = 2'd2,
    PRT_D1 = 2'd3
  } prt_e;

  function automatic int slot_w(input int pw);
    int n;
    n = LINE_W / pw;
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mps_lane.sv
module mps_lane import mps_pkg::*; #(
  parameter int ADDR_W = 14,
  parameter int NBANK  = 4,
  parameter int PW     = 64,
  localparam int PB     = PW / 8,
  localparam int NSLOT  = LINE_W / PW,
  localparam int SLOT_W = slot_w(PW),
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - LINE_LO - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PW-1:0]     wdata,
  input  logic [PB-1:0]     be,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] lwdata,
  output logic [LINE_B-1:0] lbe
);
  logic lo_unused;
  assign lo_unused = ^addr[$clog2(PB)-1:0];

  assign bank = addr[LINE_LO +: BANK_W];
  assign row  = addr[ADDR_W-1 -: ROW_W];

  generate
    if (NSLOT > 1) begin : g_slot
      assign slot = addr[$clog2(PB) +: SLOT_W];
    end else begin : g_whole
      logic slot_unused;
      assign slot_unused = ^addr[LINE_LO-1:$clog2(PB)];
      assign slot = '0;
    end
  endgenerate

  assign lwdata = {NSLOT{wdata}};
  assign lbe    = LINE_B'(be) << (slot * PB);
endmodule

// File: rtl/mps_arbiter.sv
module mps_arbiter #(
  parameter int NPORT   = 4,
  parameter int NBANK   = 4,
  parameter int MAX_GNT = 3,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = $clog2(NPORT + 1)
) (
  input  logic [NPORT-1:0]             req,
  input  logic [NPORT-1:0][BANK_W-1:0] bank,
  output logic [NPORT-1:0]             gnt
);
  logic [NBANK-1:0] taken;
  logic [CNT_W-1:0] used;

  // walk ports in rank order; a port wins if its bank is free and slots remain
  always_comb begin
    taken = '0;
    used  = '0;
    gnt   = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && !taken[bank[i]] && (used < CNT_W'(MAX_GNT))) begin
        gnt[i]         = 1'b1;
        taken[bank[i]] = 1'b1;
        used           = used + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mps_rret.sv
module mps_rret import mps_pkg::*; #(
  parameter int NBANK = 4,
  parameter int PW    = 64,
  localparam int SLOT_W = slot_w(PW),
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           take,
  input  logic [BANK_W-1:0]              bank,
  input  logic [SLOT_W-1:0]              slot,
  input  logic [NBANK-1:0][LINE_W-1:0]   mem_rdata,
  output logic                           rvalid,
  output logic [PW-1:0]                  rdata
);
  logic [BANK_W-1:0] bank_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      bank_q <= '0;
      slot_q <= '0;
    end else begin
      rvalid <= take;
      if (take) begin
        bank_q <= bank;
        slot_q <= slot;
      end
    end
  end

  assign rdata = mem_rdata[bank_q][slot_q * PW +: PW];
endmodule

// File: rtl/mps_sched.sv
module mps_sched import mps_pkg::*; #(
  parameter int ADDR_W  = 14,
  parameter int NBANK   = 4,
  parameter int MAX_GNT = 3,
  parameter int PE_W    = 32,
  parameter int DP_W    = 64,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - LINE_LO - BANK_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pe_req,
  input  logic                         pe_we,
  input  logic [ADDR_W-1:0]            pe_addr,
  input  logic [PE_W/8-1:0]            pe_be,
  input  logic [PE_W-1:0]              pe_wdata,
  output logic                         pe_gnt,
  output logic                         pe_rvalid,
  output logic [PE_W-1:0]              pe_rdata,
  input  logic                         ft_req,
  input  logic [ADDR_W-1:0]            ft_addr,
  output logic                         ft_gnt,
  output logic                         ft_rvalid,
  output logic [LINE_W-1:0]            ft_rdata,
  input  logic                         d0_req,
  input  logic                         d0_we,
  input  logic [ADDR_W-1:0]            d0_addr,
  input  logic [DP_W/8-1:0]            d0_be,
  input  logic [DP_W-1:0]              d0_wdata,
  output logic                         d0_gnt,
  output logic                         d0_rvalid,
  output logic [DP_W-1:0]              d0_rdata,
  input  logic                         d1_req,
  input  logic                         d1_we,
  input  logic [ADDR_W-1:0]            d1_addr,
  input  logic [DP_W/8-1:0]            d1_be,
  input  logic [DP_W-1:0]              d1_wdata,
  output logic                         d1_gnt,
  output logic                         d1_rvalid,
  output logic [DP_W-1:0]              d1_rdata,
  output logic [NBANK-1:0]             mem_en,
  output logic [NBANK-1:0][ROW_W-1:0]  mem_row,
  output logic [NBANK-1:0][LINE_B-1:0] mem_be,
  output logic [NBANK-1:0][LINE_W-1:0] mem_wdata,
  input  logic [NBANK-1:0][LINE_W-1:0] mem_rdata
);
  localparam int PE_SW = slot_w(PE_W);
  localparam int DP_SW = slot_w(DP_W);
  localparam int FT_SW = slot_w(LINE_W);

  logic [NPORT-1:0]             req_v, we_v, gnt;
  logic [NPORT-1:0][BANK_W-1:0] pbank;
  logic [NPORT-1:0][ROW_W-1:0]  prow;
  logic [NPORT-1:0][LINE_B-1:0] plbe;
  logic [NPORT-1:0][LINE_W-1:0] plwd;
  logic [PE_SW-1:0] pe_slot;
  logic [FT_SW-1:0] ft_slot;
  logic [DP_SW-1:0] d0_slot, d1_slot;

  assign req_v = {d1_req, d0_req, ft_req, pe_req} & {NPORT{~rst}};
  assign we_v  = {d1_we, d0_we, 1'b0, pe_we};

  mps_lane #(.ADDR_W(ADDR_W), .NBANK(NBANK), .PW(PE_W)) u_lpe (
    .addr(pe_addr), .wdata(pe_wdata), .be(pe_be), .bank(pbank[PRT_PE]),
    .row(prow[PRT_PE]), .slot(pe_slot), .lwdata(plwd[PRT_PE]), .lbe(plbe[PRT_PE]));
  mps_lane #(.ADDR_W(ADDR_W), .NBANK(NBANK), .PW(LINE_W)) u_lft (
    .addr(ft_addr), .wdata('0), .be('1), .bank(pbank[PRT_FT]),
    .row(prow[PRT_FT]), .slot(ft_slot), .lwdata(plwd[PRT_FT]), .lbe(plbe[PRT_FT]));
  mps_lane #(.ADDR_W(ADDR_W), .NBANK(NBANK), .PW(DP_W)) u_ld0 (
    .addr(d0_addr), .wdata(d0_wdata), .be(d0_be), .bank(pbank[PRT_D0]),
    .row(prow[PRT_D0]), .slot(d0_slot), .lwdata(plwd[PRT_D0]), .lbe(plbe[PRT_D0]));
  mps_lane #(.ADDR_W(ADDR_W), .NBANK(NBANK), .PW(DP_W)) u_ld1 (
    .addr(d1_addr), .wdata(d1_wdata), .be(d1_be), .bank(pbank[PRT_D1]),
    .row(prow[PRT_D1]), .slot(d1_slot), .lwdata(plwd[PRT_D1]), .lbe(plbe[PRT_D1]));

  mps_arbiter #(.NPORT(NPORT), .NBANK(NBANK), .MAX_GNT(MAX_GNT)) u_arb (
    .req(req_v), .bank(pbank), .gnt(gnt));

  assign pe_gnt = gnt[PRT_PE];
  assign ft_gnt = gnt[PRT_FT];
  assign d0_gnt = gnt[PRT_D0];
  assign d1_gnt = gnt[PRT_D1];

  // bank steering: the arbiter leaves at most one granted port per bank
  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_comb begin
        mem_en[b]    = 1'b0;
        mem_row[b]   = '0;
        mem_be[b]    = '0;
        mem_wdata[b] = '0;
        for (int p = 0; p < NPORT; p++) begin
          if (gnt[p] && (pbank[p] == BANK_W'(b))) begin
            mem_en[b]    = 1'b1;
            mem_row[b]   = prow[p];
            mem_be[b]    = we_v[p] ? plbe[p] : '0;
            mem_wdata[b] = plwd[p];
          end
        end
      end
    end
  endgenerate

  mps_rret #(.NBANK(NBANK), .PW(PE_W)) u_rpe (
    .clk(clk), .rst(rst), .take(gnt[PRT_PE] & ~pe_we), .bank(pbank[PRT_PE]),
    .slot(pe_slot), .mem_rdata(mem_rdata), .rvalid(pe_rvalid), .rdata(pe_rdata));
  mps_rret #(.NBANK(NBANK), .PW(LINE_W)) u_rft (
    .clk(clk), .rst(rst), .take(gnt[PRT_FT]), .bank(pbank[PRT_FT]),
    .slot(ft_slot), .mem_rdata(mem_rdata), .rvalid(ft_rvalid), .rdata(ft_rdata));
  mps_rret #(.NBANK(NBANK), .PW(DP_W)) u_rd0 (
    .clk(clk), .rst(rst), .take(gnt[PRT_D0] & ~d0_we), .bank(pbank[PRT_D0]),
    .slot(d0_slot), .mem_rdata(mem_rdata), .rvalid(d0_rvalid), .rdata(d0_rdata));
  mps_rret #(.NBANK(NBANK), .PW(DP_W)) u_rd1 (
    .clk(clk), .rst(rst), .take(gnt[PRT_D1] & ~d1_we), .bank(pbank[PRT_D1]),
    .slot(d1_slot), .mem_rdata(mem_rdata), .rvalid(d1_rvalid), .rdata(d1_rdata));
endmodule

// File: rtl/mps_sched_chk.sv
module mps_sched_chk #(
  parameter int ADDR_W  = 14,
  parameter int NBANK   = 4,
  parameter int MAX_GNT = 3,
  localparam int NP     = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NP-1:0]                 req,
  input logic [NP-1:0]                 gnt,
  input logic [NP-1:0]                 we,
  input logic [NP-1:0][BANK_W-1:0]     bank,
  input logic [ADDR_W-1:0]             d1_addr,
  input logic [NP-1:0]                 rvalid,
  input logic [NBANK-1:0]              mem_en
);
  logic [NBANK-1:0][NP-1:0] hit;
  always_comb begin
    for (int b = 0; b < NBANK; b++)
      for (int p = 0; p < NP; p++)
        hit[b][p] = gnt[p] && (bank[p] == BANK_W'(b));
  end

  a_r3_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt) <= MAX_GNT);

  a_r6_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);

  a_r6_one_bank_each: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_en) == $countones(gnt));

  a_r5_pe_first: assert property (@(posedge clk) disable iff (rst)
    req[0] |-> gnt[0]);

  a_r5_ft_second: assert property (@(posedge clk) disable iff (rst)
    (req[1] && !(req[0] && bank[0] == bank[1])) |-> gnt[1]);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (req[3] && !gnt[3]) |=> (req[3] && $stable(d1_addr)));

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_b
      a_r4_bank_once: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit[b]));
    end
    for (genvar p = 0; p < NP; p++) begin : g_p
      a_r7_rvalid: assert property (@(posedge clk) disable iff (rst)
        (gnt[p] && !we[p]) |=> rvalid[p]);
      a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !(gnt[p] && !we[p]) |=> !rvalid[p]);
    end
  endgenerate
endmodule

bind mps_sched mps_sched_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK), .MAX_GNT(MAX_GNT)) u_chk (
  .clk(clk), .rst(rst), .req(req_v), .gnt(gnt), .we(we_v), .bank(pbank),
  .d1_addr(d1_addr), .rvalid({d1_rvalid, d0_rvalid, ft_rvalid, pe_rvalid}),
  .mem_en(mem_en));

// File: tb/sim_mps_sched.sv
module sim_mps_sched;
  localparam int AW = 14, NB = 4, RW = AW - 5 - 2, NL = 1 << (AW - 5);

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic pe_req = 0, pe_we = 0, ft_req = 0, d0_req = 0, d0_we = 0, d1_req = 0, d1_we = 0;
  logic [AW-1:0] pe_addr = '0, ft_addr = '0, d0_addr = '0, d1_addr = '0;
  logic [3:0]  pe_be = '0;
  logic [7:0]  d0_be = '0, d1_be = '0;
  logic [31:0] pe_wdata = '0;
  logic [63:0] d0_wdata = '0, d1_wdata = '0;
  logic pe_gnt, pe_rvalid, ft_gnt, ft_rvalid, d0_gnt, d0_rvalid, d1_gnt, d1_rvalid;
  logic [31:0]  pe_rdata;
  logic [255:0] ft_rdata;
  logic [63:0]  d0_rdata, d1_rdata;
  logic [NB-1:0]            mem_en;
  logic [NB-1:0][RW-1:0]    mem_row;
  logic [NB-1:0][31:0]      mem_be;
  logic [NB-1:0][255:0]     mem_wdata;
  logic [NB-1:0][255:0]     mem_rdata;

  mps_sched u0 (.*);

  // bank models: synchronous read-first line memories, stored by line = {row, bank}
  logic [255:0] ram [NL];
  logic [255:0] shadow [NL];
  initial for (int i = 0; i < NL; i++) begin ram[i] = '0; shadow[i] = '0; end
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) if (mem_en[b]) begin
      mem_rdata[b] <= ram[{mem_row[b], 2'(b)}];
      for (int k = 0; k < 32; k++)
        if (mem_be[b][k]) ram[{mem_row[b], 2'(b)}][k*8 +: 8] <= mem_wdata[b][k*8 +: 8];
    end
  end

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R7";
  logic [3:0] lastg = '0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int c; logic [255:0] d; } exp_t;
  exp_t expq [4][$];

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exv);
    end
  endtask

  // driver: call at a negedge with inputs set; predicts grants and queues read results
  task automatic step();
    logic [3:0] r, eg, g, busy;
    logic [1:0] bk [4];
    logic [AW-1:0] ad [4];
    int used;
    #1;
    r = {d1_req, d0_req, ft_req, pe_req};
    ad[0] = pe_addr; ad[1] = ft_addr; ad[2] = d0_addr; ad[3] = d1_addr;
    for (int i = 0; i < 4; i++) bk[i] = ad[i][6:5];
    busy = '0; used = 0; eg = '0;
    for (int i = 0; i < 4; i++)
      if (r[i] && !busy[bk[i]] && used < 3) begin eg[i] = 1; busy[bk[i]] = 1; used++; end
    g = {d1_gnt, d0_gnt, ft_gnt, pe_gnt};
    chk(g == eg, $sformatf("R3/R4/R5/R6 grant vector (%s)", tag), 256'(g), 256'(eg));
    if (eg[0]) begin
      if (!pe_we) expq[0].push_back('{cyc + 1, 256'(shadow[pe_addr[13:5]][pe_addr[4:2]*32 +: 32])});
      else for (int k = 0; k < 4; k++)
        if (pe_be[k]) shadow[pe_addr[13:5]][(pe_addr[4:2]*4 + k)*8 +: 8] = pe_wdata[k*8 +: 8];
    end
    if (eg[1]) expq[1].push_back('{cyc + 1, shadow[ft_addr[13:5]]});
    if (eg[2]) begin
      if (!d0_we) expq[2].push_back('{cyc + 1, 256'(shadow[d0_addr[13:5]][d0_addr[4:3]*64 +: 64])});
      else for (int k = 0; k < 8; k++)
        if (d0_be[k]) shadow[d0_addr[13:5]][(d0_addr[4:3]*8 + k)*8 +: 8] = d0_wdata[k*8 +: 8];
    end
    if (eg[3]) begin
      if (!d1_we) expq[3].push_back('{cyc + 1, 256'(shadow[d1_addr[13:5]][d1_addr[4:3]*64 +: 64])});
      else for (int k = 0; k < 8; k++)
        if (d1_be[k]) shadow[d1_addr[13:5]][(d1_addr[4:3]*8 + k)*8 +: 8] = d1_wdata[k*8 +: 8];
    end
    lastg = g;
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected read results in the cycle they are due
  logic [255:0] rdv [4];
  logic [3:0]   rvv;
  assign rdv[0] = 256'(pe_rdata); assign rdv[1] = ft_rdata;
  assign rdv[2] = 256'(d0_rdata); assign rdv[3] = 256'(d1_rdata);
  assign rvv = {d1_rvalid, d0_rvalid, ft_rvalid, pe_rvalid};
  always @(negedge clk) if (!rst) begin
    for (int p = 0; p < 4; p++) begin
      if (expq[p].size() > 0 && expq[p][0].c == cyc) begin
        chk(rvv[p] && rdv[p] == expq[p][0].d,
            $sformatf("R7 read port %0d data (%s)", p, tag), rdv[p], expq[p][0].d);
        void'(expq[p].pop_front());
      end else if (rvv[p]) begin
        chk(1'b0, $sformatf("R7 spurious valid port %0d", p), 256'(rvv), 256'(0));
      end
    end
  end

  task automatic idle();
    pe_req = 0; ft_req = 0; d0_req = 0; d1_req = 0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk(1'b0, "watchdog expired", 256'(cyc), 256'(0));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: requests during reset are not granted and no data is returned
    pe_req = 1; ft_req = 1; d0_req = 1; d1_addr = 14'h0060; d1_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({pe_gnt, ft_gnt, d0_gnt, d1_gnt} == 4'b0, "R10 grants in reset", 256'({pe_gnt, ft_gnt, d0_gnt, d1_gnt}), 256'(0));
    chk(rvv == 4'b0, "R10 valids in reset", 256'(rvv), 256'(0));
    idle();
    rst = 0;
    step();

    // R3 / R5: four distinct banks, lowest rank waits; R9: it is retried
    tag = "R3";
    pe_req = 1; pe_we = 1; pe_addr = 14'h0004; pe_be = 4'hF; pe_wdata = 32'hA5A5_0001;
    ft_req = 1; ft_addr = 14'h0060;
    d0_req = 1; d0_we = 1; d0_addr = 14'h0028; d0_be = 8'hFF; d0_wdata = 64'h1111_2222_3333_4444;
    d1_req = 1; d1_we = 1; d1_addr = 14'h0050; d1_be = 8'hFF; d1_wdata = 64'h5555_6666_7777_8888;
    step();
    chk(lastg == 4'b0111, "R3 cap leaves data port 1 waiting", 256'(lastg), 256'(4'b0111));
    pe_req = 0; ft_req = 0; d0_req = 0;
    step();
    chk(lastg == 4'b1000, "R9 held request served on retry", 256'(lastg), 256'(4'b1000));
    idle();

    // R11 / R1: fetch sees data written by other ports, low address bits ignored
    tag = "R11";
    ft_req = 1; ft_addr = 14'h001F;
    d0_req = 1; d0_we = 0; d0_addr = 14'h0028;
    step();
    ft_addr = 14'h005B; d0_req = 0;
    tag = "R1";
    step();
    idle();

    // R8: partial writes, then read back through other ports
    tag = "R8";
    d0_req = 1; d0_we = 1; d0_addr = 14'h0028; d0_be = 8'h0F; d0_wdata = '1;
    pe_req = 1; pe_we = 1; pe_addr = 14'h0004; pe_be = 4'b0101; pe_wdata = 32'hFFFF_FFFF;
    step();
    idle();
    d1_req = 1; d1_we = 0; d1_addr = 14'h0028;
    pe_req = 1; pe_we = 0; pe_addr = 14'h0004;
    ft_req = 1; ft_addr = 14'h0040;
    step();
    idle();

    // R4 / R5: same-bank conflicts, lower rank refused then retried
    tag = "R4";
    pe_req = 1; pe_we = 0; pe_addr = 14'h0004;
    ft_req = 1; ft_addr = 14'h0000;
    d0_req = 1; d0_we = 0; d0_addr = 14'h0020;
    d1_req = 1; d1_we = 1; d1_addr = 14'h0030; d1_be = 8'hF0; d1_wdata = 64'hDEAD_BEEF_0000_0000;
    step();
    chk(lastg == 4'b0101, "R4 conflicting lower ranks refused", 256'(lastg), 256'(4'b0101));
    pe_req = 0; d0_req = 0;
    step();
    chk(lastg == 4'b1010, "R9 refused write lands on retry", 256'(lastg), 256'(4'b1010));
    idle();
    d0_req = 1; d0_we = 0; d0_addr = 14'h0030;
    step();
    idle();

    // R2: a higher row in the same bank does not alias
    tag = "R2";
    d0_req = 1; d0_we = 1; d0_addr = 14'h2028; d0_be = 8'hFF; d0_wdata = 64'hCAFE_F00D_1234_5678;
    step();
    d0_we = 0; d1_req = 1; d1_we = 0; d1_addr = 14'h0028;
    step();
    chk(lastg == 4'b0100, "R2 same bank different rows still conflict", 256'(lastg), 256'(4'b0100));
    d0_req = 0;
    step();
    idle();

    // random traffic; refused requests are held unchanged
    tag = "R7";
    for (int n = 0; n < 600; n++) begin
      if (!(pe_req && !lastg[0])) begin
        pe_req = $urandom_range(0, 1) == 1; pe_we = $urandom_range(0, 1) == 1;
        pe_addr = AW'($urandom); pe_be = 4'($urandom); pe_wdata = $urandom;
      end
      if (!(ft_req && !lastg[1])) begin
        ft_req = $urandom_range(0, 1) == 1; ft_addr = AW'($urandom);
      end
      if (!(d0_req && !lastg[2])) begin
        d0_req = $urandom_range(0, 1) == 1; d0_we = $urandom_range(0, 1) == 1;
        d0_addr = AW'($urandom); d0_be = 8'($urandom); d0_wdata = {$urandom, $urandom};
      end
      if (!(d1_req && !lastg[3])) begin
        d1_req = $urandom_range(0, 1) == 1; d1_we = $urandom_range(0, 1) == 1;
        d1_addr = AW'($urandom); d1_be = 8'($urandom); d1_wdata = {$urandom, $urandom};
      end
      step();
    end
    idle();
    step();
    step();
    chk(expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size() == 0,
        "R7 every read returned", 256'(expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()), 256'(0));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule